// File: doc/BRIEF.md
# I2C Bus Monitor

This block listens to the two wires of an I2C bus without ever driving them. It reports what it sees whether or not the traffic is meant for this node. Both lines first pass through a two-flop synchronizer and then a small glitch filter. The monitor then finds START and STOP conditions and collects each nine-clock frame, which is eight data bits sent MSB first followed by one acknowledge bit. It stores every completed byte, address bytes included, in a 32-entry receive buffer.

The block raises sticky interrupt flags for five events: a completed byte, a STOP, a not-acknowledged frame, an address match and a bus timeout. Firmware clears a flag by writing a one to the matching position of a clear vector. The timeout flag exists to catch a malformed START that is never followed by a clock pulse. It fires again each time the programmed interval runs out, until the bus clocks or a STOP appears. An own-address value of zero makes every addressed transfer count as a match.

Top module: `i2c_snoop`

## Requirements
- R1: An SDA fall while SCL is high (after filtering) begins a frame. A START that arrives inside a transfer throws away any partial bits. The next nine clocks then form a fresh first byte, which is treated as the address.
- R2: An SDA rise while SCL is high sets flag bit 7 (0x80). A partly received byte is dropped: it is not stored and it does not set bit 6.
- R3: The monitor samples SDA on each SCL rising edge. The ninth rising edge after a START or after the previous byte completes the byte. The byte is then pushed into the buffer (MSB = first bit sampled) and flag bit 6 (0x40) is set. This applies to address bytes as well as data bytes.
- R4: An acknowledge bit sampled high (NACK) sets flag bit 10 (0x400).
- R5: With `tmo_limit` nonzero, a START followed by `tmo_limit` cycles without an SCL rising edge sets flag bit 8 (0x100). While the condition lasts, it fires again every `tmo_limit` cycles. An SCL rising edge or a STOP ends it. A `tmo_limit` of 0 disables the timeout.
- R6: `rx_count` goes up by one for each stored byte and stops at 32. Each `rx_pop` lowers it by one. A pop while the count is 0 is ignored.
- R7: `rx_end_ptr` (5 bits) advances by one for every stored byte and wraps from 31 to 0. When the buffer is full, a new byte overwrites the oldest entry. `rx_data` always shows the oldest entry still held.
- R8: Flag bit 9 (0x200) is set when the first byte after a START has bits [7:1] equal to `own_addr`, or when `own_addr` is 0.
- R9: Flags stay set until a 1 is written to the same position of `irq_clr`. A new event in the same cycle as its clear takes priority. Bits 0 to 5 are always 0. `irq` is the OR of all flags.
- R10: A change on either line that lasts less than `FILT_LEN` cycles has no effect on framing or on any flag.
- R11: Reset clears all flags, the count and the end pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| own_addr | input | 7 | Address to match; 0 matches all |
| tmo_limit | input | TMO_W | Timeout interval in cycles; 0 disables |
| irq_clr | input | 11 | Write-one-to-clear vector for the flags |
| irq_stat | output | 11 | Sticky event flags |
| irq | output | 1 | OR of all flags |
| rx_pop | input | 1 | Remove the oldest buffered byte |
| rx_data | output | 8 | Oldest buffered byte |
| rx_count | output | $clog2(FIFO_DEPTH)+1 | Bytes held, saturating at FIFO_DEPTH |
| rx_end_ptr | output | $clog2(FIFO_DEPTH) | Wrapping write position |

## Verification
The bound checker runs on every cycle. It checks that the byte count never goes past 32 and never moves by more than one per cycle. It checks that the end pointer moves only, and always, when a byte completes, and that completed bytes and STOPs raise their flags. It also checks that a flag can drop only in a cycle in which its clear bit was written. The bench scenarios cover what depends on bus timing: address matching and acknowledge errors across several traffic patterns, and dropping a byte cut short by a STOP. They also cover restarting after a repeated START, a timeout that fires again and is cancelled by a clock pulse, rejection of short glitches, and overwrite at saturation with pointer wrap.

// File: rtl/i2c_snoop_pkg.sv
package i2c_snoop_pkg;

    localparam int IRQ_W    = 11;
    localparam int IRQ_BYTE = 6;
    localparam int IRQ_STOP = 7;
    localparam int IRQ_TMO  = 8;
    localparam int IRQ_HIT  = 9;
    localparam int IRQ_ACK  = 10;

    // One-cycle event record produced by the framer
    typedef struct packed {
        logic       stop;
        logic       byte_done;
        logic       ack_err;
        logic       addr_hit;
        logic       tmo;
        logic [7:0] data;
    } bus_evt_t;

    function automatic logic addr_ok(input logic [7:0] b, input logic [6:0] own);
        return (own == 7'd0) || (b[7:1] == own);
    endfunction

    function automatic logic [IRQ_W-1:0] evt_irq(input bus_evt_t e);
        logic [IRQ_W-1:0] v;
        v           = '0;
        v[IRQ_BYTE] = e.byte_done;
        v[IRQ_STOP] = e.stop;
        v[IRQ_TMO]  = e.tmo;
        v[IRQ_HIT]  = e.addr_hit;
        v[IRQ_ACK]  = e.ack_err;
        return v;
    endfunction

endpackage

// File: rtl/i2c_snoop_filt.sv
module i2c_snoop_filt #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            if (&hist_q)
                out_q <= 1'b1;
            else if (~|hist_q)
                out_q <= 1'b0;
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/i2c_snoop_frame.sv
module i2c_snoop_frame
    import i2c_snoop_pkg::*;
#(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [6:0]       own_addr,
    input  logic [TMO_W-1:0] tmo_limit,
    output bus_evt_t         evt
);
    logic             scl_p, sda_p;
    logic             active_q, first_q, pend_q;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [TMO_W-1:0] tmo_cnt;
    logic             scl_rise, start_det, stop_det;

    assign scl_rise  = scl_f & ~scl_p;
    assign start_det = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p    <= 1'b1;
            sda_p    <= 1'b1;
            active_q <= 1'b0;
            first_q  <= 1'b0;
            pend_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            tmo_cnt  <= '0;
            evt      <= '0;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
            evt   <= '0;
            if (start_det) begin
                active_q <= 1'b1;
                first_q  <= 1'b1;
                pend_q   <= 1'b1;
                bit_cnt  <= '0;
                tmo_cnt  <= '0;
            end else if (stop_det) begin
                active_q <= 1'b0;
                pend_q   <= 1'b0;
                bit_cnt  <= '0;
                evt.stop <= 1'b1;
            end else if (scl_rise && active_q) begin
                pend_q  <= 1'b0;
                tmo_cnt <= '0;
                if (bit_cnt == 4'd8) begin
                    evt.byte_done <= 1'b1;
                    evt.data      <= shreg;
                    evt.ack_err   <= sda_f;
                    evt.addr_hit  <= first_q && addr_ok(shreg, own_addr);
                    first_q       <= 1'b0;
                    bit_cnt       <= '0;
                end else begin
                    shreg   <= {shreg[6:0], sda_f};
                    bit_cnt <= bit_cnt + 4'd1;
                end
            end else if (pend_q && (tmo_limit != '0)) begin
                if (tmo_cnt == tmo_limit - 1'b1) begin
                    evt.tmo <= 1'b1;
                    tmo_cnt <= '0;
                end else begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_snoop_fifo.sv
module i2c_snoop_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [DW-1:0]            din,
    input  logic                     pop,
    output logic [DW-1:0]            dout,
    output logic [$clog2(DEPTH):0]   count,
    output logic [$clog2(DEPTH)-1:0] wr_ptr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] wp_q, rp;
    logic          pop_ok, full;

    assign full   = (cnt_q == CW'(DEPTH));
    assign pop_ok = pop && (cnt_q != '0);
    assign rp     = wp_q - cnt_q[AW-1:0];

    always_ff @(posedge clk) begin
        if (push)
            mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            wp_q  <= '0;
        end else begin
            if (push)
                wp_q <= wp_q + 1'b1;
            case ({push, pop_ok})
                2'b10:   if (!full) cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout   = mem[rp];
    assign count  = cnt_q;
    assign wr_ptr = wp_q;
endmodule

// File: rtl/i2c_snoop.sv
module i2c_snoop
    import i2c_snoop_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int FILT_LEN   = 3,
    parameter int TMO_W      = 20
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic [6:0]                    own_addr,
    input  logic [TMO_W-1:0]              tmo_limit,
    input  logic [10:0]                   irq_clr,
    output logic [10:0]                   irq_stat,
    output logic                          irq,
    input  logic                          rx_pop,
    output logic [7:0]                    rx_data,
    output logic [$clog2(FIFO_DEPTH):0]   rx_count,
    output logic [$clog2(FIFO_DEPTH)-1:0] rx_end_ptr
);
    logic [1:0] raw, filt;
    bus_evt_t   evt;
    logic [IRQ_W-1:0] irq_q;
    logic       ev_byte_w, ev_stop_w;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_snoop_filt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[g]),
            .line_o (filt[g])
        );
    end

    i2c_snoop_frame #(.TMO_W(TMO_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .scl_f     (filt[1]),
        .sda_f     (filt[0]),
        .own_addr  (own_addr),
        .tmo_limit (tmo_limit),
        .evt       (evt)
    );

    i2c_snoop_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push   (evt.byte_done),
        .din    (evt.data),
        .pop    (rx_pop),
        .dout   (rx_data),
        .count  (rx_count),
        .wr_ptr (rx_end_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= '0;
        else
            irq_q <= (irq_q & ~irq_clr) | evt_irq(evt);
    end

    assign ev_byte_w = evt.byte_done;
    assign ev_stop_w = evt.stop;
    assign irq_stat  = irq_q;
    assign irq       = |irq_q;
endmodule

// File: rtl/i2c_snoop_chk.sv
module i2c_snoop_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ev_byte,
    input logic          ev_stop,
    input logic [10:0]   irq_stat,
    input logic [10:0]   irq_clr,
    input logic [AW:0]   rx_count,
    input logic [AW-1:0] rx_end_ptr
);
    localparam int CW = AW + 1;

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        rx_count <= CW'(1 << AW));                                             // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (rx_count == $past(rx_count)) || (rx_count == $past(rx_count) + 1'b1)
        || (rx_count == $past(rx_count) - 1'b1));                              // R6
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        ev_byte |=> (rx_end_ptr == $past(rx_end_ptr) + 1'b1));                 // R7
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ev_byte |=> $stable(rx_end_ptr));                                     // R7
    AST_BYTE_FLAG: assert property (@(posedge clk) disable iff (rst)
        ev_byte |=> irq_stat[6]);                                              // R3
    AST_STOP_FLAG: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> irq_stat[7]);                                              // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(irq_stat) & ~$past(irq_clr)) & ~irq_stat) == 11'd0);          // R9
endmodule

bind i2c_snoop i2c_snoop_chk #(.AW($clog2(FIFO_DEPTH))) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_byte    (ev_byte_w),
    .ev_stop    (ev_stop_w),
    .irq_stat   (irq_stat),
    .irq_clr    (irq_clr),
    .rx_count   (rx_count),
    .rx_end_ptr (rx_end_ptr)
);

// File: tb/i2c_snoop_test.sv
module i2c_snoop_test;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1, sda = 1'b1;
    logic [6:0]  own_addr = 7'd0;
    logic [19:0] tmo_limit = 20'd1000;
    logic [10:0] irq_clr = '0;
    logic [10:0] irq_stat;
    logic        irq;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic [5:0]  rx_count;
    logic [4:0]  rx_end_ptr;

    int total = 0, bad = 0, exp_ptr = 0;

    always #4 clk = ~clk;

    i2c_snoop uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .own_addr(own_addr),
        .tmo_limit(tmo_limit), .irq_clr(irq_clr), .irq_stat(irq_stat), .irq(irq),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_count(rx_count), .rx_end_ptr(rx_end_ptr)
    );

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] dat;
        logic       na;
        logic       nd;
        logic [6:0] own;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{addr: 8'hA4, dat: 8'h3C, na: 1'b0, nd: 1'b0, own: 7'h52},
        '{addr: 8'hA5, dat: 8'hF0, na: 1'b0, nd: 1'b1, own: 7'h11},
        '{addr: 8'h22, dat: 8'h81, na: 1'b1, nd: 1'b0, own: 7'h00},
        '{addr: 8'h00, dat: 8'hFF, na: 1'b0, nd: 1'b0, own: 7'h7F},
        '{addr: 8'hFE, dat: 8'h00, na: 1'b0, nd: 1'b0, own: 7'h7F},
        '{addr: 8'h5A, dat: 8'h5A, na: 1'b1, nd: 1'b1, own: 7'h2D}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk) irq_clr = '1;
        @(negedge clk) irq_clr = '0;
    endtask

    task automatic pop1();
        @(negedge clk) rx_pop = 1'b1;
        @(negedge clk) rx_pop = 1'b0;
    endtask

    task automatic bus_start();
        sda = 1'b0; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic bus_rstart();
        sda = 1'b1; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b0; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    wait_n(H);
        scl = 1'b1; wait_n(H);
        scl = 1'b0; wait_n(H);
    endtask

    task automatic bus_byte(input logic [7:0] b, input logic nack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(nack);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_n(H);
        scl = 1'b1; wait_n(H);
        sda = 1'b1; wait_n(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [10:0] e;
        wait_n(5);
        rst = 1'b0;
        wait_n(2);
        // R11 reset state
        chk("R11 irq_stat", 32'(irq_stat), 32'h0);
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 count", 32'(rx_count), 32'h0);
        chk("R11 ptr", 32'(rx_end_ptr), 32'h0);

        // Table of two-byte transfers
        foreach (VEC[k]) begin
            own_addr = VEC[k].own;
            clear_all();
            bus_start();
            bus_byte(VEC[k].addr, VEC[k].na);
            bus_byte(VEC[k].dat, VEC[k].nd);
            bus_stop();
            wait_n(H);
            e = 11'h0C0;
            if (VEC[k].own == 7'd0 || VEC[k].addr[7:1] == VEC[k].own) e[9] = 1'b1;
            if (VEC[k].na || VEC[k].nd) e[10] = 1'b1;
            exp_ptr = (exp_ptr + 2) % 32;
            chk("R3 R4 R8 flags", 32'(irq_stat), 32'(e));
            chk("R9 irq", 32'(irq), 32'h1);
            chk("R6 count", 32'(rx_count), 32'd2);
            chk("R7 ptr", 32'(rx_end_ptr), 32'(exp_ptr));
            chk("R3 addr byte", 32'(rx_data), 32'(VEC[k].addr));
            pop1();
            chk("R3 data byte", 32'(rx_data), 32'(VEC[k].dat));
            pop1();
            chk("R6 count after pops", 32'(rx_count), 32'd0);
            @(negedge clk) irq_clr = 11'h040;
            @(negedge clk) irq_clr = '0;
            chk("R9 partial clear", 32'(irq_stat), 32'(e & ~11'h040));
            clear_all();
            chk("R9 cleared", 32'(irq_stat), 32'h0);
            chk("R9 irq low", 32'(irq), 32'h0);
        end

        // R2: STOP in mid byte drops partial data
        own_addr = 7'd0;
        clear_all();
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(1'b1);
        bus_stop();
        wait_n(H);
        chk("R2 stop flag only", 32'(irq_stat), 32'h080);
        chk("R2 no push count", 32'(rx_count), 32'd0);
        chk("R2 no push ptr", 32'(rx_end_ptr), 32'(exp_ptr));

        // R1 R8: repeated START restarts framing
        own_addr = 7'h52;
        clear_all();
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_rstart();
        bus_byte(8'hA4, 1'b0);
        bus_stop();
        wait_n(H);
        exp_ptr = (exp_ptr + 1) % 32;
        chk("R1 R8 flags", 32'(irq_stat), 32'h2C0);
        chk("R1 count", 32'(rx_count), 32'd1);
        chk("R1 byte", 32'(rx_data), 32'hA4);
        pop1();

        // R5: repeating timeout, then cancel
        tmo_limit = 20'd50;
        clear_all();
        sda = 1'b0;
        wait_n(30);
        chk("R5 not yet", 32'(irq_stat[8]), 32'h0);
        wait_n(50);
        chk("R5 fired", 32'(irq_stat[8]), 32'h1);
        clear_all();
        wait_n(60);
        chk("R5 refired", 32'(irq_stat[8]), 32'h1);
        sda = 1'b1;
        wait_n(10);
        clear_all();
        wait_n(150);
        chk("R5 stop ends", 32'(irq_stat), 32'h0);
        // SCL pulse cancels
        sda = 1'b0; wait_n(20);
        scl = 1'b0; wait_n(10);
        scl = 1'b1; wait_n(200);
        chk("R5 scl cancels", 32'(irq_stat[8]), 32'h0);
        sda = 1'b1; wait_n(H);
        clear_all();

        // R10: short glitch ignored
        @(negedge clk) sda = 1'b0;
        @(negedge clk);
        @(negedge clk) sda = 1'b1;
        wait_n(150);
        chk("R10 glitch ignored", 32'(irq_stat), 32'h0);
        tmo_limit = 20'd1000;

        // R6 R7: saturation, overwrite, wrap
        own_addr = 7'd0;
        bus_start();
        for (int k = 0; k < 34; k++) bus_byte(8'(8'h10 + k), 1'b0);
        bus_stop();
        wait_n(H);
        exp_ptr = (exp_ptr + 34) % 32;
        chk("R6 saturated", 32'(rx_count), 32'd32);
        chk("R7 wrapped ptr", 32'(rx_end_ptr), 32'(exp_ptr));
        chk("R7 oldest kept", 32'(rx_data), 32'h12);
        for (int k = 0; k < 32; k++) begin
            chk("R7 drain order", 32'(rx_data), 32'(8'(8'h12 + k)));
            pop1();
        end
        chk("R6 empty", 32'(rx_count), 32'd0);
        pop1();
        chk("R6 pop at empty", 32'(rx_count), 32'd0);
        chk("R6 ptr unchanged", 32'(rx_end_ptr), 32'(exp_ptr));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule